// File: doc/BRIEF.md
# Temperature Limit Interrupt Controller

This block watches two temperature readings and turns them into two pin levels for a system controller. Each reading is compared against a programmable upper limit and a lower hysteresis limit. Every sensor keeps a "hot" flag. The flag is set when a sample rises above the upper limit. It is cleared when a sample falls below the hysteresis limit. Each sensor also keeps a pending status bit, which is set according to the selected interrupt mode.

The interrupt pin is the OR of both pending bits. It is gated by an enable and driven at a selectable polarity. The over-temperature pin is the OR of the hot flags of the sensors whose enables are set, also at a selectable polarity. Software acknowledges interrupts with a single status-read pulse, which clears both pending bits.

The controls are plain input levels, and their values come from a register file outside the block. That register file is expected to power up with the hysteresis mode, the interrupt disabled, and both polarities active low. Temperatures are unsigned 8-bit values, and they are only examined on a cycle in which the sample-valid input is high.

Top module: `tli_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, both status bits and both hot flags clear, whatever the samples. With no pending status and no enabled hot sensor, both pins show their inactive level.
- R2: In comparator mode (irq_mode = 00), every accepted sample strictly greater than lim_over sets that sensor's status bit, including while the sensor is already hot. A sample equal to lim_over sets nothing.
- R3: A status_rd pulse clears both status bits at the next clock edge.
- R4: In two-time mode (irq_mode = 01), the sample that moves a sensor from cool to hot sets its status bit. Further samples above lim_over while the sensor stays hot set nothing.
- R5: In two-time mode, a hot sensor becomes cool on a sample strictly below lim_hyst; a sample equal to lim_hyst keeps it hot. That transition sets the status bit only if the bit was clear at that sample. A cool sensor raises nothing on further low samples.
- R6: In one-time mode (irq_mode = 10), the hot-to-cool transition sets nothing. The next cool-to-hot transition sets the status bit again.
- R7: With irq_mode = 11, no sample sets a status bit, but the hot flags still follow the limits.
- R8: When a sample sets a status bit in the same cycle as status_rd, the bit ends up set.
- R9: smi_out is at its active level (high when smi_pol = 1, low when smi_pol = 0) exactly when smi_en is 1 and some status bit is set. Otherwise it is at the opposite level.
- R10: ovt_out is active (high when ovt_pol = 1, low when 0) exactly when some sensor is hot and its bit in ovt_en (bit 0 for sensor 0) is 1.
- R11: On a cycle with sample_valid low, the temperature inputs change neither status nor hot flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_valid | input | 1 | Temperatures are examined this cycle |
| temp_in | input | 16 | Sensor 0 in bits 7:0, sensor 1 in bits 15:8, unsigned |
| lim_over | input | 8 | Over-temperature limit |
| lim_hyst | input | 8 | Hysteresis limit |
| irq_mode | input | 2 | 00 comparator, 01 two-time, 10 one-time, 11 none |
| smi_en | input | 1 | Interrupt pin enable |
| smi_pol | input | 1 | Interrupt pin polarity, 1 active high |
| ovt_en | input | 2 | Per-sensor over-temperature enables |
| ovt_pol | input | 1 | Over-temperature pin polarity, 1 active high |
| status_rd | input | 1 | Status read pulse, clears both status bits |
| smi_out | output | 1 | Interrupt pin level |
| ovt_out | output | 1 | Over-temperature pin level |
| status | output | 2 | Per-sensor pending status bits |

## Verification
If a hot flag is wrong, it shows on ovt_out in the same cycle it goes wrong, provided that sensor is enabled. It shows on status only at the next mode-dependent transition. That transition is either a missing interrupt or an extra one, one sample later. This is why the sequences move each sensor across both limits in every mode, and why they check the exact boundary values. If a pending bit is wrong, it appears on status and smi_out at the next clock edge. So every check samples the outputs one edge after the stimulus, including the cases where a read and a set share a cycle.

// File: rtl/tli_pkg.sv
// Package: shared types for the temperature limit interrupt controller.
// Assumes: mode encoding fixed by the register field that feeds irq_mode.
package tli_pkg;
    typedef enum logic [1:0] {
        TLI_MODE_CMP  = 2'b00,
        TLI_MODE_TWO  = 2'b01,
        TLI_MODE_ONE  = 2'b10,
        TLI_MODE_NONE = 2'b11
    } tli_mode_e;
endpackage

// File: rtl/tli_sensor_track.sv
// Module: per-sensor limit tracker. Holds the hot flag (set above the
// upper limit, cleared below the hysteresis limit) and the pending status
// bit, set according to the interrupt mode and cleared by a status read.
// Assumes: unsigned readings, lim_hyst not above lim_over, inputs
// considered only when sample_valid is high.
module tli_sensor_track
    import tli_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] lim_over,
    input  logic [TEMP_W-1:0] lim_hyst,
    input  tli_mode_e         mode,
    input  logic              status_rd,
    output logic              hot,
    output logic              pending
);

    logic hot_q;
    logic pend_q;
    logic above;
    logic below;
    logic rise;
    logic fall;
    logic set_evt;

    // Strict comparisons: equality counts as neither over nor under.
    assign above = temp > lim_over;
    assign below = temp < lim_hyst;
    assign rise  = sample_valid && !hot_q && above;
    assign fall  = sample_valid && hot_q && below;

    // Pick the event that sets the status bit for the selected mode.
    always_comb begin
        case (mode)
            TLI_MODE_CMP: set_evt = sample_valid && above;
            TLI_MODE_TWO: set_evt = rise || (fall && !pend_q);
            TLI_MODE_ONE: set_evt = rise;
            default:      set_evt = 1'b0;
        endcase
    end

    // Hot flag follows the two limits with hysteresis in every mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot_q <= 1'b0;
        end else if (rise) begin
            hot_q <= 1'b1;
        end else if (fall) begin
            hot_q <= 1'b0;
        end
    end

    // Pending bit: a set event wins over a simultaneous status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_evt) begin
            pend_q <= 1'b1;
        end else if (status_rd) begin
            pend_q <= 1'b0;
        end
    end

    assign hot     = hot_q;
    assign pending = pend_q;

    p_hot_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hot_q) |-> $past(sample_valid && (temp > lim_over)));

    p_hot_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hot_q) |-> $past(sample_valid && (temp < lim_hyst)));

    p_clear_by_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q) |-> $past(status_rd));

    p_set_by_sample_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(sample_valid));

    p_one_quiet_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hot_q) && $past(mode == TLI_MODE_ONE) && !$past(pend_q)) |-> !pend_q);

    p_none_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode == TLI_MODE_NONE) && !$past(pend_q)) |-> !pend_q);

endmodule

// File: rtl/tli_pin_level.sv
// Module: pin level driver. Turns a request into a pin level at the
// selected polarity, showing the inactive level when not enabled.
// Assumes: pol = 1 means active high.
module tli_pin_level (
    input  logic req,
    input  logic en,
    input  logic pol,
    output logic pin
);

    // Active level only for an enabled request, else the idle level.
    always_comb begin
        if (req && en) pin = pol;
        else           pin = !pol;
    end

endmodule

// File: rtl/tli_ctrl.sv
// Module: temperature limit interrupt controller top. Instantiates one
// tracker per sensor and two pin drivers, one for the shared interrupt
// and one for the over-temperature output.
// Assumes: sensor k occupies temp_in[k*TEMP_W +: TEMP_W]; controls are
// stable levels supplied by an external register file.
module tli_ctrl
    import tli_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int N_SENS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_valid,
    input  logic [N_SENS*TEMP_W-1:0] temp_in,
    input  logic [TEMP_W-1:0]        lim_over,
    input  logic [TEMP_W-1:0]        lim_hyst,
    input  logic [1:0]               irq_mode,
    input  logic                     smi_en,
    input  logic                     smi_pol,
    input  logic [N_SENS-1:0]        ovt_en,
    input  logic                     ovt_pol,
    input  logic                     status_rd,
    output logic                     smi_out,
    output logic                     ovt_out,
    output logic [N_SENS-1:0]        status
);

    tli_mode_e         mode;
    logic [N_SENS-1:0] hot_vec;
    logic [N_SENS-1:0] pend_vec;
    logic              ovt_req;

    assign mode = tli_mode_e'(irq_mode);

    // One tracker per sensor, each on its own slice of temp_in.
    for (genvar k = 0; k < N_SENS; k++) begin : g_sens
        tli_sensor_track #(.TEMP_W(TEMP_W)) u_track (
            .clk          (clk),
            .rst_n        (rst_n),
            .sample_valid (sample_valid),
            .temp         (temp_in[k*TEMP_W +: TEMP_W]),
            .lim_over     (lim_over),
            .lim_hyst     (lim_hyst),
            .mode         (mode),
            .status_rd    (status_rd),
            .hot          (hot_vec[k]),
            .pending      (pend_vec[k])
        );
    end

    assign ovt_req = |(hot_vec & ovt_en);
    assign status  = pend_vec;

    tli_pin_level u_smi_pin (
        .req (|pend_vec),
        .en  (smi_en),
        .pol (smi_pol),
        .pin (smi_out)
    );

    tli_pin_level u_ovt_pin (
        .req (ovt_req),
        .en  (1'b1),
        .pol (ovt_pol),
        .pin (ovt_out)
    );

    p_smi_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pend_vec) == 0) |-> (smi_out == !smi_pol));

    p_smi_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_en && (pend_vec != '0)) |-> (smi_out == smi_pol));

    p_ovt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((hot_vec & ovt_en) == '0) |-> (ovt_out == !ovt_pol));

endmodule

// File: tb/tli_ctrl_bench.sv
module tli_ctrl_bench;

    typedef struct {
        logic [1:0] st;
        logic       smi;
        logic       ovt;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] temp_in = '0;
    logic [7:0]  lim_over = 8'd100;
    logic [7:0]  lim_hyst = 8'd80;
    logic [1:0]  irq_mode = 2'b00;
    logic        smi_en = 1'b1;
    logic        smi_pol = 1'b1;
    logic [1:0]  ovt_en = 2'b11;
    logic        ovt_pol = 1'b1;
    logic        status_rd = 1'b0;
    logic        smi_out;
    logic        ovt_out;
    logic [1:0]  status;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t q[$];
    event item_ev;

    always #10 clk = ~clk;

    tli_ctrl u_tli_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .temp_in      (temp_in),
        .lim_over     (lim_over),
        .lim_hyst     (lim_hyst),
        .irq_mode     (irq_mode),
        .smi_en       (smi_en),
        .smi_pol      (smi_pol),
        .ovt_en       (ovt_en),
        .ovt_pol      (ovt_pol),
        .status_rd    (status_rd),
        .smi_out      (smi_out),
        .ovt_out      (ovt_out),
        .status       (status)
    );

    // Monitor: pops one expected item per step and compares the ports.
    initial begin
        forever begin
            @(item_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (status !== e.st || smi_out !== e.smi || ovt_out !== e.ovt) begin
                    bad++;
                    $display("FAIL %s: status=%b smi=%b ovt=%b expected status=%b smi=%b ovt=%b",
                             e.req, status, smi_out, ovt_out, e.st, e.smi, e.ovt);
                end
            end
        end
    end

    // Driver: apply one cycle of stimulus, then queue the expected outputs.
    task automatic step(input logic [7:0] ta, input logic [7:0] tb,
                        input logic sv, input logic rd,
                        input logic [1:0] st, input logic smi, input logic ovt,
                        input string req);
        exp_t e;
        temp_in      = {tb, ta};
        sample_valid = sv;
        status_rd    = rd;
        @(posedge clk);
        #1;
        e.st = st; e.smi = smi; e.ovt = ovt; e.req = req;
        q.push_back(e);
        -> item_ev;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: samples during reset leave everything clear
        step(8'd200, 8'd200, 1, 0, 2'b00, 0, 0, "R1");
        rst_n = 1'b1;

        // Comparator mode
        step(8'd100, 8'd50, 1, 0, 2'b00, 0, 0, "R2 equal to limit");
        step(8'd101, 8'd50, 1, 0, 2'b01, 1, 1, "R2 above limit");
        step(8'd50,  8'd50, 0, 0, 2'b01, 1, 1, "R11 no valid");
        step(8'd50,  8'd50, 0, 1, 2'b00, 0, 1, "R3 read clears");
        step(8'd101, 8'd120, 1, 0, 2'b11, 1, 1, "R2 level while hot");
        step(8'd101, 8'd120, 1, 1, 2'b11, 1, 1, "R8 set beats read");
        step(8'd80,  8'd79, 1, 1, 2'b00, 0, 1, "R10 equal hyst stays hot");
        step(8'd79,  8'd79, 1, 0, 2'b00, 0, 0, "R10 both cool");

        // Two-time mode
        irq_mode = 2'b01;
        step(8'd101, 8'd50, 1, 0, 2'b01, 1, 1, "R4 rise");
        step(8'd150, 8'd50, 1, 1, 2'b00, 0, 1, "R4 no refire while hot");
        step(8'd80,  8'd50, 1, 0, 2'b00, 0, 1, "R5 equal hyst");
        step(8'd79,  8'd50, 1, 0, 2'b01, 1, 0, "R5 second interrupt");
        step(8'd50,  8'd50, 0, 1, 2'b00, 0, 0, "R3 read");
        step(8'd101, 8'd50, 1, 0, 2'b01, 1, 1, "R4 rise again");
        step(8'd50,  8'd50, 1, 0, 2'b01, 1, 0, "R5 fall with pending");
        step(8'd50,  8'd50, 0, 1, 2'b00, 0, 0, "R3 read");
        step(8'd50,  8'd50, 1, 0, 2'b00, 0, 0, "R5 cool stays quiet");

        // One-time mode
        irq_mode = 2'b10;
        step(8'd101, 8'd50, 1, 0, 2'b01, 1, 1, "R6 rise");
        step(8'd50,  8'd50, 0, 1, 2'b00, 0, 1, "R3 read");
        step(8'd50,  8'd50, 1, 0, 2'b00, 0, 0, "R6 fall silent");
        step(8'd101, 8'd50, 1, 0, 2'b01, 1, 1, "R6 refire");

        // Reserved mode
        irq_mode = 2'b11;
        step(8'd50,  8'd50, 0, 1, 2'b00, 0, 1, "R3 read");
        step(8'd50,  8'd50, 1, 0, 2'b00, 0, 0, "R7 fall");
        step(8'd120, 8'd120, 1, 0, 2'b00, 0, 1, "R7 rise silent");
        step(8'd50,  8'd50, 1, 0, 2'b00, 0, 0, "R7 cool");

        // Pin polarity and enables
        irq_mode = 2'b01;
        step(8'd50, 8'd101, 1, 0, 2'b10, 1, 1, "R4 sensor 1 rise");
        smi_pol = 1'b0;
        step(8'd50, 8'd101, 0, 0, 2'b10, 0, 1, "R9 active low");
        smi_en = 1'b0;
        step(8'd50, 8'd101, 0, 0, 2'b10, 1, 1, "R9 disabled");
        ovt_en = 2'b01;
        step(8'd50, 8'd101, 0, 0, 2'b10, 1, 0, "R10 sensor 1 masked");
        ovt_en = 2'b10;
        step(8'd50, 8'd101, 0, 0, 2'b10, 1, 1, "R10 sensor 1 enabled");
        ovt_pol = 1'b0;
        step(8'd50, 8'd101, 0, 0, 2'b10, 1, 0, "R10 active low");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule